// File: doc/BRIEF.md
# Winding Current Chopper

This block keeps the current in one motor winding near its target by chopping at a fixed rate, and drives the four gate controls of the H-bridge that feeds that winding. Every chopping period opens with the bridge driving current in the commanded direction. An external comparator reports through a trip bit when the sensed current reaches the threshold. Once that report is accepted, the bridge leaves drive and decays until the period ends. Trip reports that arrive in an opening blanking window are ignored, so the window also sets a floor on the drive time.

Three decay styles are available. Slow decay turns both low-side switches on so the current recirculates. Fast decay reverses the bridge and turns everything off once a zero-current detect bit fires. Mixed decay runs fast decay up to a fixed point in the period and slow decay after it, but only while the commanded magnitude is falling; otherwise it uses slow decay. Each leg passes through a dead-time guard, so its two switches are never on together and never switch over without a gap. Output 1 of the bridge is leg 1 and output 2 is leg 2. Positive current flows from output 1 to output 2.

Top module: `wchop_top`

## Requirements
- R1: While reset is asserted all four gate outputs are 0. In the first cycle after release with enable high, the bridge drives in the commanded direction.
- R2: The chopping period is PER clock cycles long. Each period starts in drive. With dir_pos=1, drive turns on hi1_en and lo2_en. With dir_pos=0, drive turns on hi2_en and lo1_en.
- R3: A trip seen while the period counter is below BLANK-1 is ignored. With trip held high, drive lasts BLANK cycles of the period.
- R4: Once a trip is accepted, the bridge stays in decay until the period ends, even after trip falls again.
- R5: decay_sel=2'b00 selects slow decay: lo1_en and lo2_en on, both high sides off.
- R6: decay_sel=2'b10 or 2'b11 selects fast decay, which reverses the drive pattern. After zero_det is seen during fast decay, all four gates stay off until the period ends.
- R7: decay_sel=2'b01 selects mixed decay. If mag_falling=1, it uses fast decay while the counter is below MIX and slow decay from MIX on. If mag_falling=0, it uses slow decay.
- R8: With en low, all four gate outputs are 0 in the same cycle. The period counter restarts, so a new period begins in the first cycle en is high again.
- R9: When a switch in a leg turns off, the other switch of that leg stays off for at least DEAD cycles before it turns on.
- R10: The two switches of one leg are never on at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Bridge enable; low forces all gates off |
| trip | input | 1 | Current-threshold comparator output |
| zero_det | input | 1 | Winding current near zero |
| dir_pos | input | 1 | Target current sign, 1 = positive |
| mag_falling | input | 1 | Target magnitude is decreasing |
| decay_sel | input | 2 | 00 slow, 01 mixed, 10/11 fast |
| hi1_en | output | 1 | Leg 1 high-side gate enable |
| lo1_en | output | 1 | Leg 1 low-side gate enable |
| hi2_en | output | 1 | Leg 2 high-side gate enable |
| lo2_en | output | 1 | Leg 2 low-side gate enable |

## Verification
The counter, the trip latch and the zero latch each change on the edge that closes the cycle in which their condition held. A gate request is taken into its leg register one edge later, so a gate pattern shows one cycle after the counter value or input that caused it. When the pattern crosses within a leg, the incoming switch turns on DEAD cycles after the outgoing one turns off. The enable mask is the only path with no register, and it acts in the same cycle. The bench models these latencies with its own counter and leg state, updated on the rising edge. It drives inputs and compares all four outputs on the falling edge. It sweeps the decay codes, signs, falling flag, trip arrival points and zero-detect arrival points on a small configuration, and pauses enable between runs.

// File: rtl/wchop_pkg.sv
package wchop_pkg;

  typedef enum logic [1:0] {
    PH_OFF   = 2'd0,
    PH_DRIVE = 2'd1,
    PH_FAST  = 2'd2,
    PH_SLOW  = 2'd3
  } phase_e;

  typedef enum logic [1:0] {
    DK_SLOW  = 2'd0,
    DK_MIXED = 2'd1,
    DK_FAST  = 2'd2
  } decay_e;

  function automatic decay_e decode_decay(input logic [1:0] code);
    if (code == 2'b00)      return DK_SLOW;
    else if (code == 2'b01) return DK_MIXED;
    else                    return DK_FAST;
  endfunction

  // returns {hi, lo} request for leg 0 (output 1) or leg 1 (output 2)
  function automatic logic [1:0] leg_req(input phase_e ph, input logic pos,
                                         input logic leg);
    logic pol;
    logic [1:0] r;
    r = 2'b00;
    pol = (ph == PH_FAST) ? ~pos : pos;
    case (ph)
      PH_DRIVE, PH_FAST: r = ((pol ^ leg) == 1'b1) ? 2'b10 : 2'b01;
      PH_SLOW:           r = 2'b01;
      default:           r = 2'b00;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/wchop_timer.sv
module wchop_timer #(
  parameter int PER = 400,
  parameter int CW  = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  output logic [CW-1:0] cnt,
  output logic          wrap
);
  localparam logic [CW-1:0] LAST = CW'(PER - 1);

  assign wrap = en && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (!en)   cnt <= '0;
    else if (wrap)  cnt <= '0;
    else            cnt <= cnt + 1'b1;
  end

  a_r8_restart: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt == '0));
  a_r2_period_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (en && cnt == LAST) |=> (cnt == '0));
endmodule

// File: rtl/wchop_phase.sv
module wchop_phase
  import wchop_pkg::*;
#(
  parameter int CW    = 9,
  parameter int BLANK = 75,
  parameter int MIX   = 300
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          trip,
  input  logic          zero_det,
  input  logic          mag_falling,
  input  logic [1:0]    decay_sel,
  input  logic [CW-1:0] cnt,
  input  logic          wrap,
  output phase_e        phase
);
  localparam logic [CW-1:0] BLANK_M1 = CW'(BLANK - 1);
  localparam logic [CW-1:0] MIX_PT   = CW'(MIX);

  logic   chopped;
  logic   zhit;
  logic   accept;
  decay_e mode;
  phase_e fast_leg;

  assign mode     = decode_decay(decay_sel);
  assign accept   = en && !wrap && !chopped && trip && (cnt >= BLANK_M1);
  assign fast_leg = zhit ? PH_OFF : PH_FAST;

  always_comb begin
    phase = PH_DRIVE;
    if (!en) phase = PH_OFF;
    else if (chopped) begin
      case (mode)
        DK_SLOW:  phase = PH_SLOW;
        DK_FAST:  phase = fast_leg;
        default:  phase = (!mag_falling || cnt >= MIX_PT) ? PH_SLOW : fast_leg;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chopped <= 1'b0;
      zhit    <= 1'b0;
    end else if (!en || wrap) begin
      chopped <= 1'b0;
      zhit    <= 1'b0;
    end else begin
      if (accept) chopped <= 1'b1;
      if (phase == PH_FAST && zero_det) zhit <= 1'b1;
    end
  end

  a_r3_blank: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chopped) |-> ($past(cnt) >= BLANK_M1 && $past(trip)));
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (chopped && en && !wrap) |=> chopped);
  a_r6_fast_after_trip: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_FAST) |-> (chopped && mode != DK_SLOW && !zhit));
endmodule

// File: rtl/wchop_leg.sv
module wchop_leg #(
  parameter int DEAD = 8,
  parameter int DW   = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hi_req,
  input  logic lo_req,
  output logic hi_q,
  output logic lo_q
);
  localparam logic [DW-1:0] DEAD_V = DW'(DEAD);

  logic [DW-1:0] idle;
  logic          gap_done;

  assign gap_done = (idle >= DEAD_V);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= 1'b0;
      lo_q <= 1'b0;
      idle <= DEAD_V;
    end else if (hi_q && !hi_req) begin
      hi_q <= 1'b0;
      idle <= DW'(1);
    end else if (lo_q && !lo_req) begin
      lo_q <= 1'b0;
      idle <= DW'(1);
    end else if (!hi_q && !lo_q) begin
      if (hi_req && gap_done)      hi_q <= 1'b1;
      else if (lo_req && gap_done) lo_q <= 1'b1;
      else if (!gap_done)          idle <= idle + 1'b1;
    end
  end

  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(hi_q && lo_q));
  a_r9_dead_hi: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hi_q) |-> ($past(idle) >= DEAD_V));
  a_r9_dead_lo: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lo_q) |-> ($past(idle) >= DEAD_V));
endmodule

// File: rtl/wchop_top.sv
module wchop_top
  import wchop_pkg::*;
#(
  parameter int PER   = 400,
  parameter int BLANK = 75,
  parameter int MIX   = 300,
  parameter int DEAD  = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       trip,
  input  logic       zero_det,
  input  logic       dir_pos,
  input  logic       mag_falling,
  input  logic [1:0] decay_sel,
  output logic       hi1_en,
  output logic       lo1_en,
  output logic       hi2_en,
  output logic       lo2_en
);
  localparam int CW = $clog2(PER);
  localparam int DW = $clog2(DEAD + 1);

  logic [CW-1:0] cnt;
  logic          wrap;
  phase_e        phase;
  logic [1:0]    leg_hi;
  logic [1:0]    leg_lo;

  wchop_timer #(.PER(PER), .CW(CW)) timer_i (
    .clk(clk), .rst_n(rst_n), .en(en), .cnt(cnt), .wrap(wrap)
  );

  wchop_phase #(.CW(CW), .BLANK(BLANK), .MIX(MIX)) phase_i (
    .clk(clk), .rst_n(rst_n), .en(en), .trip(trip), .zero_det(zero_det),
    .mag_falling(mag_falling), .decay_sel(decay_sel), .cnt(cnt),
    .wrap(wrap), .phase(phase)
  );

  for (genvar g = 0; g < 2; g++) begin : g_leg
    logic [1:0] req;
    assign req = leg_req(phase, dir_pos, 1'(g));
    wchop_leg #(.DEAD(DEAD), .DW(DW)) leg_i (
      .clk(clk), .rst_n(rst_n), .hi_req(req[1]), .lo_req(req[0]),
      .hi_q(leg_hi[g]), .lo_q(leg_lo[g])
    );
  end

  assign hi1_en = leg_hi[0] & en;
  assign lo1_en = leg_lo[0] & en;
  assign hi2_en = leg_hi[1] & en;
  assign lo2_en = leg_lo[1] & en;

  a_r8_gates_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !(hi1_en || lo1_en || hi2_en || lo2_en));
  a_r5_slow_pattern: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(phase) == PH_SLOW && phase == PH_SLOW && leg_lo[0] && leg_lo[1])
      |-> !(hi1_en || hi2_en));
endmodule

// File: tb/wchop_top_tb_top.sv
module wchop_top_tb_top;
  localparam int PER = 40, BLANK = 8, MIX = 30, DEAD = 3;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, trip = 1'b0, zero_det = 1'b0;
  logic dir_pos = 1'b1, mag_falling = 1'b0;
  logic [1:0] decay_sel = 2'b00;
  logic hi1_en, lo1_en, hi2_en, lo2_en;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  wchop_top #(.PER(PER), .BLANK(BLANK), .MIX(MIX), .DEAD(DEAD)) dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .trip(trip), .zero_det(zero_det),
    .dir_pos(dir_pos), .mag_falling(mag_falling), .decay_sel(decay_sel),
    .hi1_en(hi1_en), .lo1_en(lo1_en), .hi2_en(hi2_en), .lo2_en(lo2_en)
  );

  // bench model: 0 off, 1 drive, 2 fast, 3 slow
  int m_cnt = 0, m_chop = 0, m_zhit = 0;
  int m_hi [2] = '{0, 0};
  int m_lo [2] = '{0, 0};
  int m_idle [2] = '{DEAD, DEAD};

  function automatic int m_phase();
    int fastv;
    fastv = m_zhit ? 0 : 2;
    if (!en) return 0;
    if (!m_chop) return 1;
    if (decay_sel == 2'b00) return 3;
    if (decay_sel == 2'b01) return (!mag_falling || m_cnt >= MIX) ? 3 : fastv;
    return fastv;
  endfunction

  // which switch a leg wants: 0 none, 1 high, 2 low
  function automatic int m_want(int ph, int leg);
    int sign;
    if (ph == 0) return 0;
    if (ph == 3) return 2;
    sign = (ph == 1) ? int'(dir_pos) : 1 - int'(dir_pos);
    if (leg == 0) return sign ? 1 : 2;
    return sign ? 2 : 1;
  endfunction

  always @(posedge clk) begin
    int ph, w;
    bit last;
    if (!rst_n) begin
      m_cnt = 0; m_chop = 0; m_zhit = 0;
      for (int l = 0; l < 2; l++) begin m_hi[l] = 0; m_lo[l] = 0; m_idle[l] = DEAD; end
    end else begin
      ph = m_phase();
      for (int l = 0; l < 2; l++) begin
        w = m_want(ph, l);
        if (m_hi[l] && w != 1) begin m_hi[l] = 0; m_idle[l] = 1; end
        else if (m_lo[l] && w != 2) begin m_lo[l] = 0; m_idle[l] = 1; end
        else if (!m_hi[l] && !m_lo[l]) begin
          if (w == 1 && m_idle[l] >= DEAD) m_hi[l] = 1;
          else if (w == 2 && m_idle[l] >= DEAD) m_lo[l] = 1;
          else if (m_idle[l] < DEAD) m_idle[l]++;
        end
      end
      last = (m_cnt == PER - 1);
      if (!en || last) begin m_chop = 0; m_zhit = 0; end
      else begin
        if (!m_chop && trip && m_cnt >= BLANK - 1) m_chop = 1;
        if (ph == 2 && zero_det) m_zhit = 1;
      end
      m_cnt = (!en || last) ? 0 : m_cnt + 1;
    end
  end

  function automatic string req_of(int ph);
    if (ph == 0) return en ? "R6" : "R8";
    if (ph == 1) return (m_cnt < BLANK) ? "R3" : "R2";
    if (!trip) return "R4";
    if (decay_sel == 2'b01) return "R7";
    if (ph == 3) return "R5";
    return "R6";
  endfunction

  task automatic check(string req, logic [3:0] got, logic [3:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%b expected=%b at cnt=%0d t=%0t", req, got, exp, m_cnt, $time);
    end
  endtask

  task automatic compare_model();
    logic [3:0] exp;
    exp = {1'(m_hi[0]) & en, 1'(m_lo[0]) & en, 1'(m_hi[1]) & en, 1'(m_lo[1]) & en};
    check(req_of(m_phase()), {hi1_en, lo1_en, hi2_en, lo2_en}, exp);
  endtask

  // R9 / R10 monitors on the ports
  int off_lo [2] = '{99, 99};
  int off_hi [2] = '{99, 99};
  logic prev_hi [2] = '{0, 0};
  logic prev_lo [2] = '{0, 0};
  always @(negedge clk) if (rst_n) begin
    logic h [2], l [2];
    h[0] = hi1_en; l[0] = lo1_en; h[1] = hi2_en; l[1] = lo2_en;
    for (int g = 0; g < 2; g++) begin
      if (h[g] && l[g]) begin n_chk++; n_bad++;
        $display("FAIL R10 leg%0d got=both expected=one", g); end
      if (h[g] && !prev_hi[g]) begin n_chk++;
        if (off_lo[g] < DEAD) begin n_bad++;
          $display("FAIL R9 leg%0d gap got=%0d expected>=%0d", g, off_lo[g], DEAD); end
      end
      if (l[g] && !prev_lo[g]) begin n_chk++;
        if (off_hi[g] < DEAD) begin n_bad++;
          $display("FAIL R9 leg%0d gap got=%0d expected>=%0d", g, off_hi[g], DEAD); end
      end
      off_lo[g] = l[g] ? 0 : off_lo[g] + 1;
      off_hi[g] = h[g] ? 0 : off_hi[g] + 1;
      prev_hi[g] = h[g]; prev_lo[g] = l[g];
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog got=timeout expected=finish");
    finish_run();
  end

  initial begin
    int tlist [4] = '{0, 12, 25, 99};
    repeat (3) @(negedge clk);
    check("R1", {hi1_en, lo1_en, hi2_en, lo2_en}, 4'b0000);
    en = 1'b1; dir_pos = 1'b1; decay_sel = 2'b00;
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {hi1_en, lo1_en, hi2_en, lo2_en}, 4'b1001);
    repeat (PER) begin @(negedge clk); compare_model(); end

    for (int d = 0; d < 4; d++)
      for (int s = 0; s < 2; s++)
        for (int f = 0; f < 2; f++)
          for (int ti = 0; ti < 4; ti++)
            for (int zi = 0; zi < 2; zi++) begin
              int t_at, z_at;
              t_at = tlist[ti];
              z_at = zi ? 99 : t_at + 4;
              en = 1'b0; trip = 1'b0; zero_det = 1'b0;
              repeat (3) begin
                @(negedge clk);
                check("R8", {hi1_en, lo1_en, hi2_en, lo2_en}, 4'b0000);
              end
              decay_sel = 2'(d); dir_pos = 1'(s); mag_falling = 1'(f);
              en = 1'b1;
              trip = (m_cnt >= t_at); zero_det = (m_cnt >= z_at);
              repeat (2 * PER) begin
                @(negedge clk);
                compare_model();
                trip = (m_cnt >= t_at);
                zero_det = (m_cnt >= z_at);
              end
            end
    // R4: trip pulse of one cycle after blanking still holds decay
    en = 1'b0; @(negedge clk);
    decay_sel = 2'b00; dir_pos = 1'b1; en = 1'b1; trip = 1'b0;
    repeat (PER + 2) begin
      @(negedge clk); compare_model();
      trip = (m_cnt == 15);
    end
    finish_run();
  end
endmodule